// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block holds the time of day and the calendar date in packed BCD and advances them by one second on each pulse of a one-second tick input. It counts seconds, minutes and hours (24-hour form), a day-of-week value, the day of the month, the month, a two-digit year, and a century flag that may follow year rollover. The oscillator and the prescaler that make the tick, and any serial bus, are outside the block.

Software sets any field through a register-style load port: a write strobe, a 3-bit field select and a data byte. The same port carries a stop control that freezes counting and a sticky oscillator-fail flag. Each write to a field raises a one-cycle request so the external prescaler can restart its sub-second count. Parallel outputs present every field in its register layout for copying into user-visible registers.

Top module: `cal_time_core`

## Requirements
- R1: Seconds and minutes count 00 to 59 and hours 00 to 23 in BCD; a units digit of 9 steps to 0 with a tens carry, and a field at its top value returns to 00 and carries one step into the next field.
- R2: The day of week (field 3, bits 2:0) counts 1 to 7 and returns to 1 when the hours wrap from 23 to 00.
- R3: The day of month wraps back to 01 after 31 in months 01, 03, 05, 07, 08, 10, 12, after 30 in months 04, 06, 09, 11, and after 28 or 29 in month 02; the month wraps from 12 to 01 and the year from 99 to 00.
- R4: February ends at 29 when the two-digit year is a multiple of 4 (00 included) and at 28 otherwise.
- R5: At a year wrap from 99 to 00 the century flag (field 2, bit 6) inverts when the century enable (field 2, bit 7) is 1 and holds when it is 0.
- R6: While the stop bit (field 0, bit 7) is 1, ticks do not change any time or date field and the oscillator-fail flag is forced to 1.
- R7: The oscillator-fail flag (field 1, bit 7) is 1 after reset, stays 1 across ticks, and only a write of 0 to it (with stop at 0) clears it.
- R8: A write to fields 0 to 6 drives `div_clr_o` high in the following cycle for one cycle; a tick arriving in the cycle of a write is discarded.
- R9: Unused bits read as 0 whatever is written: day-of-week bits 7:3, date bits 7:6, month bits 7:5.
- R10: A units digit written above 9 becomes 0, with a tens carry, at the next increment of that field.
- R11: After reset the fields read seconds 00, minutes 00 with fail 1, hours 00 with both century bits 0, day 1, date 01, month 01, year 00, and `div_clr_o` is 0.
- R12: Field select codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year; code 7 writes nothing and raises no divider request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field select for the write |
| wr_data_i | input | 8 | Byte written to the selected field |
| sec_o | output | 8 | Stop bit and BCD seconds |
| min_o | output | 8 | Oscillator-fail flag and BCD minutes |
| hour_o | output | 8 | Century enable, century flag and BCD hours |
| dow_o | output | 8 | Day of week in bits 2:0 |
| date_o | output | 8 | BCD day of month |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD two-digit year |
| div_clr_o | output | 1 | One-cycle request to restart the sub-second divider |

## Verification
On every cycle the assertions check that a stopped core holds all time fields and raises the fail flag, that the fail flag and the century flag change only through their allowed causes, that a running tick always moves the seconds, and that the divider request tracks field writes exactly. The calendar arithmetic itself (month lengths, leap years, the century flip at 99, day-of-week wrap, illegal digit recovery and masked bits) depends on chosen start values, so only the bench's directed scenarios show it.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC   = 3'd0,
    SEL_MIN   = 3'd1,
    SEL_HOUR  = 3'd2,
    SEL_DOW   = 3'd3,
    SEL_DATE  = 3'd4,
    SEL_MONTH = 3'd5,
    SEL_YEAR  = 3'd6
  } cal_sel_e;

  localparam int unsigned SEC_W   = 7;
  localparam int unsigned HOUR_W  = 6;
  localparam int unsigned DOW_W   = 3;
  localparam int unsigned DATE_W  = 6;
  localparam int unsigned MONTH_W = 5;
  localparam int unsigned YEAR_W  = 8;

  // Two-digit BCD year divisible by four: even tens need units 0/4/8,
  // odd tens need units 2/6.
  function automatic logic yr_is_leap(input logic [YEAR_W-1:0] yr);
    logic [3:0] u;
    u = yr[3:0];
    if (!yr[4]) return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
    else        return (u == 4'd2) || (u == 4'd6);
  endfunction

  // Last day of the month in BCD.
  function automatic logic [DATE_W-1:0] month_last_day(
      input logic [MONTH_W-1:0] mon, input logic [YEAR_W-1:0] yr);
    case (mon)
      5'h02:                      return yr_is_leap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/cal_bcd_step.sv
module cal_bcd_step #(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic         en_i,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);
  localparam int unsigned TENS_W = W - 4;

  logic at_top;
  logic [TENS_W-1:0] tens_inc;

  assign at_top   = (cur_i >= hi_i);
  assign tens_inc = cur_i[W-1:4] + 1'b1;
  assign wrap_o   = en_i && at_top;

  always_comb begin
    if (!en_i)                 nxt_o = cur_i;
    else if (at_top)           nxt_o = lo_i;
    else if (cur_i[3:0] >= 4'd9) nxt_o = {tens_inc, 4'h0};
    else                       nxt_o = cur_i + 1'b1;
  end
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core
  import cal_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       div_clr_o
);
  logic rst_q_n;

  cal_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n_o(rst_q_n)
  );

  logic [SEC_W-1:0]   sec_q, sec_d, sec_s;
  logic [SEC_W-1:0]   min_q, min_d, min_s;
  logic [HOUR_W-1:0]  hour_q, hour_d, hour_s;
  logic [DOW_W-1:0]   dow_q, dow_d, dow_s;
  logic [DATE_W-1:0]  date_q, date_d, date_s, date_top;
  logic [MONTH_W-1:0] mon_q, mon_d, mon_s;
  logic [YEAR_W-1:0]  year_q, year_d, year_s;
  logic stop_q, stop_d, fail_q, fail_d;
  logic cen_en_q, cen_en_d, cen_q, cen_d;
  logic div_clr_q;

  logic wr_hit, run, state_en;
  logic sec_wrap, min_wrap, hour_wrap, date_wrap, mon_wrap, year_wrap;

  assign wr_hit   = wr_en_i && (wr_sel_i <= SEL_YEAR);
  assign run      = tick_i && !stop_q && !wr_hit;
  assign state_en = run || wr_hit || stop_q;
  assign date_top = month_last_day(mon_q, year_q);

  cal_bcd_step #(.W(SEC_W)) u_sec (
    .cur_i(sec_q), .lo_i(7'h00), .hi_i(7'h59), .en_i(run),
    .nxt_o(sec_s), .wrap_o(sec_wrap));

  cal_bcd_step #(.W(SEC_W)) u_min (
    .cur_i(min_q), .lo_i(7'h00), .hi_i(7'h59), .en_i(sec_wrap),
    .nxt_o(min_s), .wrap_o(min_wrap));

  cal_bcd_step #(.W(HOUR_W)) u_hour (
    .cur_i(hour_q), .lo_i(6'h00), .hi_i(6'h23), .en_i(min_wrap),
    .nxt_o(hour_s), .wrap_o(hour_wrap));

  cal_bcd_step #(.W(DATE_W)) u_date (
    .cur_i(date_q), .lo_i(6'h01), .hi_i(date_top), .en_i(hour_wrap),
    .nxt_o(date_s), .wrap_o(date_wrap));

  cal_bcd_step #(.W(MONTH_W)) u_mon (
    .cur_i(mon_q), .lo_i(5'h01), .hi_i(5'h12), .en_i(date_wrap),
    .nxt_o(mon_s), .wrap_o(mon_wrap));

  cal_bcd_step #(.W(YEAR_W)) u_year (
    .cur_i(year_q), .lo_i(8'h00), .hi_i(8'h99), .en_i(mon_wrap),
    .nxt_o(year_s), .wrap_o(year_wrap));

  // Day of week follows the day carry, wrapping 7 -> 1.
  always_comb begin
    if (!hour_wrap)          dow_s = dow_q;
    else if (dow_q >= 3'd7)  dow_s = 3'd1;
    else                     dow_s = dow_q + 3'd1;
  end

  always_comb begin
    sec_d    = sec_s;
    min_d    = min_s;
    hour_d   = hour_s;
    dow_d    = dow_s;
    date_d   = date_s;
    mon_d    = mon_s;
    year_d   = year_s;
    stop_d   = stop_q;
    fail_d   = fail_q || stop_q;
    cen_en_d = cen_en_q;
    cen_d    = cen_q ^ (year_wrap && cen_en_q);
    if (wr_hit) begin
      case (wr_sel_i)
        SEL_SEC: begin
          sec_d  = wr_data_i[6:0];
          stop_d = wr_data_i[7];
        end
        SEL_MIN: begin
          min_d  = wr_data_i[6:0];
          fail_d = wr_data_i[7] || stop_q;
        end
        SEL_HOUR: begin
          hour_d   = wr_data_i[5:0];
          cen_d    = wr_data_i[6];
          cen_en_d = wr_data_i[7];
        end
        SEL_DOW:   dow_d  = wr_data_i[2:0];
        SEL_DATE:  date_d = wr_data_i[5:0];
        SEL_MONTH: mon_d  = wr_data_i[4:0];
        default:   year_d = wr_data_i;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sec_q    <= '0;
      min_q    <= '0;
      hour_q   <= '0;
      dow_q    <= 3'd1;
      date_q   <= 6'h01;
      mon_q    <= 5'h01;
      year_q   <= '0;
      stop_q   <= 1'b0;
      fail_q   <= 1'b1;
      cen_en_q <= 1'b0;
      cen_q    <= 1'b0;
    end else if (state_en) begin
      sec_q    <= sec_d;
      min_q    <= min_d;
      hour_q   <= hour_d;
      dow_q    <= dow_d;
      date_q   <= date_d;
      mon_q    <= mon_d;
      year_q   <= year_d;
      stop_q   <= stop_d;
      fail_q   <= fail_d;
      cen_en_q <= cen_en_d;
      cen_q    <= cen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) div_clr_q <= 1'b0;
    else          div_clr_q <= wr_hit;
  end

  assign sec_o     = {stop_q, sec_q};
  assign min_o     = {fail_q, min_q};
  assign hour_o    = {cen_en_q, cen_q, hour_q};
  assign dow_o     = {5'b0, dow_q};
  assign date_o    = {2'b0, date_q};
  assign month_o   = {3'b0, mon_q};
  assign year_o    = year_q;
  assign div_clr_o = div_clr_q;
endmodule

// File: rtl/cal_time_core_chk.sv
module cal_time_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [2:0] wr_sel_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic       div_clr_o
);
  logic field_wr;
  assign field_wr = wr_en_i && (wr_sel_i != 3'd7);

  a_r6_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[7] && !wr_en_i) |=> ($stable(sec_o[6:0]) && $stable(min_o[6:0]) &&
      $stable(hour_o[5:0]) && $stable(dow_o) && $stable(date_o) &&
      $stable(month_o) && $stable(year_o)));

  a_r6_stop_sets_fail: assert property (@(posedge clk) disable iff (!rst_n)
    sec_o[7] |=> min_o[7]);

  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (min_o[7] && !(wr_en_i && wr_sel_i == 3'd1)) |=> min_o[7]);

  a_r5_century_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hour_o[7] && !(wr_en_i && wr_sel_i == 3'd2)) |=> $stable(hour_o[6]));

  a_r1_sec_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !sec_o[7] && !field_wr) |=> !$stable(sec_o[6:0]));

  a_r8_div_clr_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    field_wr |=> div_clr_o);

  a_r8_div_clr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_wr) |=> !div_clr_o);
endmodule

bind cal_time_core cal_time_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .tick_i   (tick_i),
  .wr_en_i  (wr_en_i),
  .wr_sel_i (wr_sel_i),
  .sec_o    (sec_o),
  .min_o    (min_o),
  .hour_o   (hour_o),
  .dow_o    (dow_o),
  .date_o   (date_o),
  .month_o  (month_o),
  .year_o   (year_o),
  .div_clr_o(div_clr_o)
);

// File: tb/cal_time_core_test.sv
module cal_time_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_sel_i = 3'd0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic       div_clr_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cal_time_core uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .sec_o(sec_o), .min_o(min_o),
    .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o), .month_o(month_o),
    .year_o(year_o), .div_clr_o(div_clr_o));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = s; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic tick1();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                         input logic [7:0] dw, input logic [7:0] dt,
                         input logic [7:0] mo, input logic [7:0] yr);
    wr(3'd2, h); wr(3'd1, m); wr(3'd0, s); wr(3'd3, dw);
    wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, yr);
  endtask

  task automatic t_reset();
    chk("R11 sec", sec_o, 8'h00);   chk("R11 min/fail", min_o, 8'h80);
    chk("R11 hour", hour_o, 8'h00); chk("R11 dow", dow_o, 8'h01);
    chk("R11 date", date_o, 8'h01); chk("R11 month", month_o, 8'h01);
    chk("R11 year", year_o, 8'h00); chk("R11 div_clr", {7'b0, div_clr_o}, 8'h00);
    tick1();
    chk("R7 fail kept over tick", min_o, 8'h80);
    chk("R1 first second", sec_o, 8'h01);
  endtask

  task automatic t_digits();
    wr(3'd0, 8'h09); tick1();
    chk("R1 units carry", sec_o, 8'h10);
    wr(3'd0, 8'h0C); tick1();
    chk("R10 illegal units", sec_o, 8'h10);
    set_all(8'h05, 8'h59, 8'h59, 8'h03, 8'h10, 8'h06, 8'h20);
    tick1();
    chk("R1 minute wrap sec", sec_o, 8'h00);
    chk("R1 hour carry", hour_o, 8'h06);
    chk("R1 minute wrap min", min_o, 8'h00);
  endtask

  task automatic t_midnight();
    set_all(8'h23, 8'h59, 8'h59, 8'h07, 8'h14, 8'h08, 8'h21);
    tick1();
    chk("R1 hour wrap", hour_o, 8'h00);
    chk("R2 dow 7->1", dow_o, 8'h01);
    chk("R3 date step", date_o, 8'h15);
    set_all(8'h23, 8'h59, 8'h59, 8'h02, 8'h28, 8'h02, 8'h23);
    tick1();
    chk("R4 non-leap feb date", date_o, 8'h01);
    chk("R4 non-leap feb month", month_o, 8'h03);
    chk("R2 dow step", dow_o, 8'h03);
    set_all(8'h23, 8'h59, 8'h59, 8'h02, 8'h28, 8'h02, 8'h24);
    tick1();
    chk("R4 leap feb 29", date_o, 8'h29);
    set_all(8'h23, 8'h59, 8'h59, 8'h02, 8'h28, 8'h02, 8'h00);
    tick1();
    chk("R4 year 00 leap", date_o, 8'h29);
    set_all(8'h23, 8'h59, 8'h59, 8'h02, 8'h30, 8'h04, 8'h05);
    tick1();
    chk("R3 30-day month", month_o, 8'h05);
    chk("R3 30-day date", date_o, 8'h01);
    set_all(8'h23, 8'h59, 8'h59, 8'h02, 8'h30, 8'h07, 8'h05);
    tick1();
    chk("R3 31-day month", date_o, 8'h31);
  endtask

  task automatic t_century();
    set_all(8'hA3, 8'h59, 8'h59, 8'h01, 8'h31, 8'h12, 8'h99);
    tick1();
    chk("R3 year wrap", year_o, 8'h00);
    chk("R3 month wrap", month_o, 8'h01);
    chk("R5 century toggles", hour_o, 8'hC0);
    set_all(8'h63, 8'h59, 8'h59, 8'h01, 8'h31, 8'h12, 8'h99);
    tick1();
    chk("R5 century held", hour_o, 8'h40);
  endtask

  task automatic t_stop();
    wr(3'd1, 8'h05);
    chk("R7 fail cleared", min_o, 8'h05);
    wr(3'd0, 8'h90);
    @(negedge clk);
    chk("R6 stop sets fail", min_o, 8'h85);
    tick1();
    chk("R6 frozen", sec_o, 8'h90);
    wr(3'd1, 8'h05);
    chk("R7 clear blocked while stopped", min_o, 8'h85);
    wr(3'd0, 8'h10);
    tick1();
    chk("R6 runs after stop", sec_o, 8'h11);
    chk("R7 fail still set", min_o, 8'h85);
    wr(3'd1, 8'h05);
    chk("R7 fail cleared by write", min_o, 8'h05);
  endtask

  task automatic t_div();
    @(negedge clk);
    chk("R8 idle", {7'b0, div_clr_o}, 8'h00);
    wr(3'd4, 8'h12);
    chk("R8 pulse", {7'b0, div_clr_o}, 8'h01);
    @(negedge clk);
    chk("R8 one cycle", {7'b0, div_clr_o}, 8'h00);
    wr(3'd7, 8'h55);
    chk("R12 sel 7 no pulse", {7'b0, div_clr_o}, 8'h00);
    chk("R12 sel 7 no effect", date_o, 8'h12);
    wr(3'd0, 8'h20);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = 3'd0; wr_data_i = 8'h30; tick_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
    chk("R8 tick dropped on write", sec_o, 8'h30);
  endtask

  task automatic t_masks();
    wr(3'd3, 8'hFF); chk("R9 dow mask", dow_o, 8'h07);
    wr(3'd4, 8'hFF); chk("R9 date mask", date_o, 8'h3F);
    wr(3'd5, 8'hFF); chk("R9 month mask", month_o, 8'h1F);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_digits();
    t_midnight();
    t_century();
    t_stop();
    t_div();
    t_masks();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule